// File: doc/BRIEF.md
# Split-Access 64-bit Microsecond Timebase

This block keeps a 64-bit count of microseconds since reset. The count is reached through a 32-bit APB slave port. The counter advances by one on every clock cycle in which the microsecond tick input is high and no pause condition holds.

Software works on the value one 32-bit half at a time:

- **Setting the time.** Software writes the low half first. That value is held in a staging register. The write to the high half then replaces all 64 bits of the count in one step.
- **Reading the time.** Software reads the low half first. That read copies the live upper 32 bits into a shadow register. The following high-half read returns the shadow, so the two words together form one coherent 64-bit value.
- **Raw views.** Two further registers return the live halves and change no staging or shadow state.

Counting stops when either of these holds:

- the software pause bit is set, or
- a debug-halt input from one of two processors is active while its matching enable bit is set.

The port has no wait states and never signals an error.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count is zero, the pause register reads 0 and the debug-pause register at 0x2C reads 0x6.
- R2: On each clock edge where `tick_i` is high and no pause condition holds, the count increases by exactly one. The carry passes from bit 31 into bit 32. When `tick_i` is low the count holds.
- R3: Writes to the low-half write register (0x04) go only into the staging register and leave the count unchanged. A write to the high-half write register (0x00) loads the count with {written data, staged low half}.
- R4: A high-half load that coincides with a tick takes priority: after that edge the count equals the loaded value, not the loaded value plus one.
- R5: A read of the low-half read register (0x0C) returns the live low 32 bits. In the same access it captures the live high 32 bits into a shadow. The high-half read register (0x08) returns that shadow, not the live value.
- R6: The raw registers at 0x24 (high) and 0x28 (low) return the live count halves and leave the shadow unchanged.
- R7: Bit 0 of the pause register (0x30), when 1, stops the count. Clearing it resumes counting.
- R8: In the debug-pause register (0x2C), bit 1 gates `halt0_i` and bit 2 gates `halt1_i`. While a bit is 1 and its halt input is high, the count stops. A cleared bit makes its halt input have no effect.
- R9: Reads of unmapped addresses, of the write-only registers 0x00 and 0x04, or of any address whose two low bits are nonzero return zero. Writes to read-only registers (0x08, 0x0C, 0x24, 0x28) leave the count unchanged.
- R10: `pready` is high on every access, so each transfer completes in its access phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| tick_i | input | 1 | One-microsecond tick enable |
| halt0_i | input | 1 | Debug-halt from processor 0 |
| halt1_i | input | 1 | Debug-halt from processor 1 |

## Verification
The bound assertions check the following on every clock edge:

- the single-step increment,
- holding with the tick low,
- holding under software pause or a gated debug halt,
- the full 64-bit load from the high-half write,
- shadow capture on low-half reads,
- raw reads leaving the shadow untouched.

Other behaviours need a sequence of accesses and show only in the bench scenarios:

- reset values read back through the port,
- a staged low half surviving until the high write,
- a load winning over a coincident tick,
- the carry into the upper word,
- a stale shadow persisting across a reload,
- unmapped and read-only addresses.

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int ADDR_W = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              tick_i,
  input  logic              halt0_i,
  input  logic              halt1_i
);
  localparam int WI_W = ADDR_W - 2;
  localparam logic [WI_W-1:0] W_SET_HI = WI_W'(6'h00);
  localparam logic [WI_W-1:0] W_SET_LO = WI_W'(6'h01);
  localparam logic [WI_W-1:0] W_GET_HI = WI_W'(6'h02);
  localparam logic [WI_W-1:0] W_GET_LO = WI_W'(6'h03);
  localparam logic [WI_W-1:0] W_RAW_HI = WI_W'(6'h09);
  localparam logic [WI_W-1:0] W_RAW_LO = WI_W'(6'h0A);
  localparam logic [WI_W-1:0] W_DBG    = WI_W'(6'h0B);
  localparam logic [WI_W-1:0] W_HOLD   = WI_W'(6'h0C);

  logic [63:0] cnt_q;
  logic [31:0] stage_q, shadow_q;
  logic        pause_q;
  logic [1:0]  dbg_en_q;

  wire [WI_W-1:0] widx   = paddr[ADDR_W-1:2];
  wire            align  = (paddr[1:0] == 2'b00);
  wire            acc    = psel & penable & align;
  wire            wr     = acc & pwrite;
  wire            rd     = acc & ~pwrite;
  wire            ld_hi  = wr & (widx == W_SET_HI);
  wire            halted = (dbg_en_q[0] & halt0_i) | (dbg_en_q[1] & halt1_i);
  wire            run    = tick_i & ~pause_q & ~halted;

  assign pready = 1'b1;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      cnt_q <= '0;
    end else if (ld_hi) begin
      cnt_q <= {pwdata, stage_q};
    end else if (run) begin
      cnt_q <= cnt_q + 64'd1;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      stage_q  <= '0;
      pause_q  <= 1'b0;
      dbg_en_q <= 2'b11;
    end else if (wr) begin
      if (widx == W_SET_LO) stage_q  <= pwdata;
      if (widx == W_HOLD)   pause_q  <= pwdata[0];
      if (widx == W_DBG)    dbg_en_q <= pwdata[2:1];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)                      shadow_q <= '0;
    else if (rd && widx == W_GET_LO)   shadow_q <= cnt_q[63:32];
  end

  always_comb begin
    prdata = '0;
    if (align) begin
      case (widx)
        W_GET_HI: prdata = shadow_q;
        W_GET_LO: prdata = cnt_q[31:0];
        W_RAW_HI: prdata = cnt_q[63:32];
        W_RAW_LO: prdata = cnt_q[31:0];
        W_DBG:    prdata = {29'd0, dbg_en_q, 1'b0};
        W_HOLD:   prdata = {31'd0, pause_q};
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
  parameter int ADDR_W = 8
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              tick_i,
  input logic              halt0_i,
  input logic              halt1_i,
  input logic [63:0]       cnt_q,
  input logic [31:0]       stage_q,
  input logic [31:0]       shadow_q,
  input logic              pause_q,
  input logic [1:0]        dbg_en_q
);
  wire acc  = psel & penable;
  wire load = acc & pwrite & (paddr == ADDR_W'(8'h00));
  wire rlo  = acc & ~pwrite & (paddr == ADDR_W'(8'h0C));
  wire rraw = acc & ~pwrite & ((paddr == ADDR_W'(8'h24)) | (paddr == ADDR_W'(8'h28)));
  wire free = tick_i & ~pause_q & ~(dbg_en_q[0] & halt0_i) & ~(dbg_en_q[1] & halt1_i);

  AST_LOAD_ALL64: assert property (@(posedge pclk) disable iff (!presetn)
    load |=> cnt_q == {$past(pwdata), $past(stage_q)}); // R3
  AST_INC_ONE: assert property (@(posedge pclk) disable iff (!presetn)
    (!load && free) |=> cnt_q == $past(cnt_q) + 64'd1); // R2
  AST_IDLE_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    (!load && !tick_i) |=> $stable(cnt_q)); // R2
  AST_SW_PAUSE: assert property (@(posedge pclk) disable iff (!presetn)
    (!load && pause_q) |=> $stable(cnt_q)); // R7
  AST_DBG_HALT: assert property (@(posedge pclk) disable iff (!presetn)
    (!load && ((dbg_en_q[0] && halt0_i) || (dbg_en_q[1] && halt1_i))) |=> $stable(cnt_q)); // R8
  AST_SHADOW_CAP: assert property (@(posedge pclk) disable iff (!presetn)
    rlo |=> shadow_q == $past(cnt_q[63:32])); // R5
  AST_RAW_NOSIDE: assert property (@(posedge pclk) disable iff (!presetn)
    rraw |=> $stable(shadow_q)); // R6
endmodule

bind usec_timebase usec_timebase_chk #(.ADDR_W(ADDR_W)) chk_i (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .tick_i(tick_i), .halt0_i(halt0_i), .halt1_i(halt1_i),
  .cnt_q(cnt_q), .stage_q(stage_q), .shadow_q(shadow_q), .pause_q(pause_q),
  .dbg_en_q(dbg_en_q));

// File: tb/usec_timebase_tb_top.sv
module usec_timebase_tb_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        tick_i = 1'b0, halt0_i = 1'b0, halt1_i = 1'b0;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 pclk = ~pclk;

  usec_timebase dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .tick_i(tick_i), .halt0_i(halt0_i), .halt1_i(halt1_i));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per read access phase.
  initial forever begin
    @(negedge pclk); #1;
    if (psel && penable) begin
      check("R10 pready", {31'd0, pready}, 32'd1);
      if (!pwrite && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, prdata, e);
      end
    end
  end

  task automatic apb_read(logic [7:0] a, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic apb_write(logic [7:0] a, logic [31:0] d, bit with_tick = 0);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1; tick_i = with_tick;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0; tick_i = 0;
  endtask

  task automatic ticks(int n);
    @(negedge pclk); tick_i = 1;
    repeat (n - 1) @(negedge pclk);
    @(negedge pclk); tick_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    // R1 reset state
    apb_read(8'h0C, 32'h0, "R1 low read");
    apb_read(8'h08, 32'h0, "R1 high read");
    apb_read(8'h2C, 32'h6, "R1 dbg pause reset");
    apb_read(8'h30, 32'h0, "R1 pause reset");
    // R2 counting
    ticks(5);
    apb_read(8'h28, 32'd5, "R2 five ticks");
    repeat (4) @(negedge pclk);
    apb_read(8'h28, 32'd5, "R2 hold tick low");
    // R3 staged load
    apb_write(8'h04, 32'h0000_1234);
    apb_read(8'h28, 32'd5, "R3 staged no effect");
    apb_write(8'h00, 32'h0000_00AB);
    apb_read(8'h24, 32'h0000_00AB, "R3 loaded high");
    apb_read(8'h28, 32'h0000_1234, "R3 loaded low");
    // R4 load beats tick
    apb_write(8'h04, 32'hFFFF_FFFF);
    apb_write(8'h00, 32'h0000_0001, 1);
    apb_read(8'h28, 32'hFFFF_FFFF, "R4 low after load+tick");
    apb_read(8'h24, 32'h0000_0001, "R4 high after load+tick");
    ticks(1);
    apb_read(8'h28, 32'h0, "R2 carry low");
    apb_read(8'h24, 32'h2, "R2 carry high");
    // R5 shadow
    apb_read(8'h0C, 32'h0, "R5 low read captures");
    apb_write(8'h04, 32'h10);
    apb_write(8'h00, 32'h7);
    apb_read(8'h08, 32'h2, "R5 shadow not live");
    apb_read(8'h0C, 32'h10, "R5 low live");
    apb_read(8'h08, 32'h7, "R5 shadow updated");
    // R6 raw no side effect
    apb_write(8'h00, 32'h9);
    apb_read(8'h24, 32'h9, "R6 raw high live");
    apb_read(8'h28, 32'h10, "R6 raw low live");
    apb_read(8'h08, 32'h7, "R6 shadow untouched");
    // R7 software pause
    apb_write(8'h30, 32'h1);
    apb_read(8'h30, 32'h1, "R7 pause readback");
    ticks(3);
    apb_read(8'h28, 32'h10, "R7 paused");
    apb_write(8'h30, 32'h0);
    ticks(2);
    apb_read(8'h28, 32'h12, "R7 resumed");
    // R8 debug halts
    halt0_i = 1;
    ticks(3);
    apb_read(8'h28, 32'h12, "R8 halt0 stops");
    apb_write(8'h2C, 32'h4);
    apb_read(8'h2C, 32'h4, "R8 dbg readback");
    ticks(2);
    apb_read(8'h28, 32'h14, "R8 halt0 masked");
    halt1_i = 1;
    ticks(2);
    apb_read(8'h28, 32'h14, "R8 halt1 stops");
    halt0_i = 0; halt1_i = 0;
    // R9 unmapped / read-only
    apb_read(8'h34, 32'h0, "R9 unmapped");
    apb_read(8'h00, 32'h0, "R9 write-only reads zero");
    apb_read(8'h0D, 32'h0, "R9 misaligned");
    apb_write(8'h28, 32'hDEAD_BEEF);
    apb_write(8'h0C, 32'hDEAD_BEEF);
    apb_write(8'h24, 32'hDEAD_BEEF);
    apb_read(8'h28, 32'h14, "R9 ro write low ignored");
    apb_read(8'h24, 32'h9, "R9 ro write high ignored");
    repeat (3) @(negedge pclk);
    if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule